// File: doc/BRIEF.md
# In-flight Instruction Tag Allocator

This block hands out instruction tags for a two-thread out-of-order core. In every cycle the issue side serves one thread. It takes up to four decoded instructions of that thread, together with a per-slot flag that says whether the slot's execution resources are free. It grants the longest run of instructions, starting at slot 0, that can all proceed. Each granted instruction receives a tag that no other in-flight instruction holds.

The commit side also serves one thread per cycle. It receives completion flags for that thread's four oldest in-flight instructions and retires the leading run of completed ones. It then reports the tags it freed. Each thread keeps its tags in a circular order list, so retirement always releases the oldest tags first. A per-thread flush returns all of that thread's outstanding tags to the pool in a single cycle.

The grants and commits are combinational functions of the current state and inputs. All state changes on the rising clock edge.

Top module: `inflight_tag_alloc`

## Requirements
- R1: Each granted tag lies in 0..63 and is held by no other in-flight instruction. Granted slots receive the lowest-numbered free tags in ascending order: slot 0 gets the lowest.
- R2: At most four instructions are granted per cycle. Slot k is granted only if slots 0..k are all valid, have free resources and can each receive a tag. The grant vector is therefore an in-order prefix (bit 0 = slot 0).
- R3: While both threads are active, a thread holds at most 32 tags. While only one thread is active, it may hold up to 64 tags. A thread that already holds more than its cap is granted nothing.
- R4: Issue prefers the thread not served by the previous successful issue. If the preferred thread can be granted nothing, the other thread is served. With no grant at all, `iss_thr_o` shows the preferred thread.
- R5: Commit retires up to four instructions of one thread in program order. Ready bit k (bit t*4+k of `cmt_rdy_i`) refers to the k-th oldest in-flight instruction of thread t. The retired set is the leading run of ready bits, limited by the number of in-flight instructions. The reported tags are the oldest ones, oldest in slot 0.
- R6: Commit alternates threads by the same preference and fallback rule as issue.
- R7: A flush of thread t frees all of its tags in one cycle and suppresses issue and commit for thread t in that cycle. The freed tags can be granted from the next cycle on.
- R8: After reset no tag is in flight, all 64 are free, and thread 0 is preferred first on both sides.
- R9: A tag retired in a cycle cannot be granted in that same cycle, only from the next one.
- R10: Issue inputs of an inactive thread (`thr_act_i[t]`=0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_act_i | input | 2 | Thread active flags, bit t = thread t |
| flush_i | input | 2 | Flush request per thread |
| iss_vld_i | input | 8 | Decoded instruction valid, bit t*4+k = thread t slot k |
| iss_res_i | input | 8 | Resources free for that slot |
| cmt_rdy_i | input | 8 | Completion flag of k-th oldest instruction of thread t |
| iss_gnt_o | output | 4 | Granted issue slots of served thread |
| iss_thr_o | output | 1 | Thread served at issue |
| iss_tag_o | output | 24 | Tag of slot k at bits k*6+:6, zero if not granted |
| cmt_vld_o | output | 4 | Retired slots of served thread |
| cmt_thr_o | output | 1 | Thread served at commit |
| cmt_tag_o | output | 24 | Retired tag of slot k at bits k*6+:6, zero if not retired |

## Verification
A vector table runs several patterns, each meant to separate one behaviour from its neighbours. A full four-slot group checks plain allocation. A resource hole in the middle of a group shows that later free slots still wait. An idle preferred thread exposes the fallback rule. A partial ready run checks in-order retirement, and a flush with traffic on the other thread shows that the two threads stay independent. Directed runs then fill one thread up to 32 and then up to 64 tags while tracking tag uniqueness, drain the oldest tags into an empty pool to check same-cycle reuse, and apply reset in the middle of a run.

// File: rtl/inflight_tag_pkg.sv
package inflight_tag_pkg;
  localparam int unsigned NTHR = 2;
  localparam logic THR_FIRST = 1'b0;
endpackage

// File: rtl/prefix_grant.sv
module prefix_grant #(
  parameter int unsigned GRP = 4,
  parameter int unsigned LW  = 7,
  localparam int unsigned NW = $clog2(GRP + 1)
) (
  input  logic [GRP-1:0] req_i,
  input  logic [LW-1:0]  limit_i,
  output logic [GRP-1:0] gnt_o,
  output logic [NW-1:0]  num_o
);
  always_comb begin
    logic run;
    run   = 1'b1;
    num_o = '0;
    gnt_o = '0;
    for (int k = 0; k < GRP; k++) begin
      run      = run & req_i[k] & (LW'(k) < limit_i);
      gnt_o[k] = run;
      num_o    = num_o + NW'(run);
    end
  end
endmodule

// File: rtl/tag_free_pick.sv
module tag_free_pick #(
  parameter int unsigned NUM_TAGS = 64,
  parameter int unsigned GRP      = 4,
  localparam int unsigned TW      = $clog2(NUM_TAGS)
) (
  input  logic [NUM_TAGS-1:0]     free_i,
  output logic [GRP-1:0]          found_o,
  output logic [GRP*TW-1:0]       tag_o,
  output logic [GRP*NUM_TAGS-1:0] oh_o
);
  always_comb begin
    logic [NUM_TAGS-1:0] rem, oh;
    logic                hit;
    rem     = free_i;
    found_o = '0;
    tag_o   = '0;
    oh_o    = '0;
    for (int k = 0; k < GRP; k++) begin
      hit = 1'b0;
      oh  = '0;
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (!hit && rem[i]) begin
          hit               = 1'b1;
          oh[i]             = 1'b1;
          tag_o[k*TW+:TW]   = TW'(i);
        end
      end
      found_o[k]                  = hit;
      oh_o[k*NUM_TAGS+:NUM_TAGS]  = oh;
      rem                         = rem & ~oh;
    end
  end
endmodule

// File: rtl/thr_pick.sv
module thr_pick (
  input  logic       last_i,
  input  logic [1:0] has_i,
  output logic       sel_o
);
  logic pref;
  assign pref  = ~last_i;
  assign sel_o = has_i[pref] ? pref : (has_i[~pref] ? ~pref : pref);
endmodule

// File: rtl/tag_ring.sv
module tag_ring #(
  parameter int unsigned NUM_TAGS = 64,
  parameter int unsigned GRP      = 4,
  localparam int unsigned TW      = $clog2(NUM_TAGS),
  localparam int unsigned CW      = TW + 1,
  localparam int unsigned NW      = $clog2(GRP + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [NW-1:0]       push_n_i,
  input  logic [GRP*TW-1:0]   push_tag_i,
  input  logic [NW-1:0]       pop_n_i,
  output logic [CW-1:0]       cnt_o,
  output logic [GRP*TW-1:0]   head_tag_o,
  output logic [NUM_TAGS-1:0] held_o
);
  logic [TW-1:0]       mem [NUM_TAGS];
  logic [TW-1:0]       head_q, tail_q;
  logic [CW-1:0]       cnt_q;
  logic [NUM_TAGS-1:0] held_q, held_d;

  always_comb begin
    for (int k = 0; k < GRP; k++) head_tag_o[k*TW+:TW] = mem[head_q + TW'(k)];
  end

  always_comb begin
    held_d = held_q;
    for (int k = 0; k < GRP; k++)
      if (NW'(k) < pop_n_i) held_d[head_tag_o[k*TW+:TW]] = 1'b0;
    for (int k = 0; k < GRP; k++)
      if (NW'(k) < push_n_i) held_d[push_tag_i[k*TW+:TW]] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < GRP; k++)
      if (NW'(k) < push_n_i) mem[tail_q + TW'(k)] <= push_tag_i[k*TW+:TW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else if (flush_i) begin
      head_q <= tail_q;
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      head_q <= head_q + TW'(pop_n_i);
      tail_q <= tail_q + TW'(push_n_i);
      cnt_q  <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
      held_q <= held_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign held_o = held_q;
endmodule

// File: rtl/inflight_tag_alloc.sv
module inflight_tag_alloc
  import inflight_tag_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 64,
  parameter int unsigned GRP      = 4,
  localparam int unsigned TW      = $clog2(NUM_TAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NTHR-1:0]      thr_act_i,
  input  logic [NTHR-1:0]      flush_i,
  input  logic [NTHR*GRP-1:0]  iss_vld_i,
  input  logic [NTHR*GRP-1:0]  iss_res_i,
  input  logic [NTHR*GRP-1:0]  cmt_rdy_i,
  output logic [GRP-1:0]       iss_gnt_o,
  output logic                 iss_thr_o,
  output logic [GRP*TW-1:0]    iss_tag_o,
  output logic [GRP-1:0]       cmt_vld_o,
  output logic                 cmt_thr_o,
  output logic [GRP*TW-1:0]    cmt_tag_o
);
  localparam int unsigned CW = TW + 1;
  localparam int unsigned NW = $clog2(GRP + 1);
  localparam logic [CW-1:0] CAP_ALL  = CW'(NUM_TAGS);
  localparam logic [CW-1:0] CAP_HALF = CW'(NUM_TAGS / NTHR);

  logic [NUM_TAGS-1:0]     free_q, free_d, alloc_m, ret_m, fl_m;
  logic [GRP-1:0]          found;
  logic [GRP*TW-1:0]       ftag;
  logic [GRP*NUM_TAGS-1:0] foh;
  logic [CW-1:0]           cap;

  logic [GRP-1:0]      igr  [NTHR];
  logic [GRP-1:0]      cgr  [NTHR];
  logic [NW-1:0]       inum [NTHR];
  logic [NW-1:0]       cnum [NTHR];
  logic [CW-1:0]       cnt  [NTHR];
  logic [CW-1:0]       room [NTHR];
  logic [GRP*TW-1:0]   htag [NTHR];
  logic [NUM_TAGS-1:0] held [NTHR];
  logic [NTHR-1:0]     ihas, chas;
  logic                isel, csel, ilast_q, clast_q;

  tag_free_pick #(.NUM_TAGS(NUM_TAGS), .GRP(GRP)) u_pick (
    .free_i (free_q),
    .found_o(found),
    .tag_o  (ftag),
    .oh_o   (foh)
  );

  // cap halves while both threads run
  assign cap = (&thr_act_i) ? CAP_HALF : CAP_ALL;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [GRP-1:0] ireq, creq;

    assign room[t] = (cnt[t] >= cap) ? '0 : cap - cnt[t];
    assign ireq = iss_vld_i[t*GRP+:GRP] & iss_res_i[t*GRP+:GRP] & found
                & {GRP{thr_act_i[t] & ~flush_i[t]}};
    assign creq = cmt_rdy_i[t*GRP+:GRP] & {GRP{~flush_i[t]}};

    prefix_grant #(.GRP(GRP), .LW(CW)) u_igrant (
      .req_i  (ireq),
      .limit_i(room[t]),
      .gnt_o  (igr[t]),
      .num_o  (inum[t])
    );

    prefix_grant #(.GRP(GRP), .LW(CW)) u_cgrant (
      .req_i  (creq),
      .limit_i(cnt[t]),
      .gnt_o  (cgr[t]),
      .num_o  (cnum[t])
    );

    assign ihas[t] = |igr[t];
    assign chas[t] = |cgr[t];

    tag_ring #(.NUM_TAGS(NUM_TAGS), .GRP(GRP)) u_ring (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i[t]),
      .push_n_i  ((isel == 1'(t)) ? inum[t] : '0),
      .push_tag_i(ftag),
      .pop_n_i   ((csel == 1'(t)) ? cnum[t] : '0),
      .cnt_o     (cnt[t]),
      .head_tag_o(htag[t]),
      .held_o    (held[t])
    );
  end

  thr_pick u_ipick (.last_i(ilast_q), .has_i(ihas), .sel_o(isel));
  thr_pick u_cpick (.last_i(clast_q), .has_i(chas), .sel_o(csel));

  assign iss_gnt_o = igr[isel];
  assign iss_thr_o = isel;
  assign cmt_vld_o = cgr[csel];
  assign cmt_thr_o = csel;

  always_comb begin
    for (int k = 0; k < GRP; k++) begin
      iss_tag_o[k*TW+:TW] = iss_gnt_o[k] ? ftag[k*TW+:TW] : '0;
      cmt_tag_o[k*TW+:TW] = cmt_vld_o[k] ? htag[csel][k*TW+:TW] : '0;
    end
  end

  always_comb begin
    alloc_m = '0;
    ret_m   = '0;
    fl_m    = '0;
    for (int k = 0; k < GRP; k++) begin
      if (iss_gnt_o[k]) alloc_m = alloc_m | foh[k*NUM_TAGS+:NUM_TAGS];
      if (cmt_vld_o[k]) ret_m[cmt_tag_o[k*TW+:TW]] = 1'b1;
    end
    for (int t = 0; t < NTHR; t++)
      if (flush_i[t]) fl_m = fl_m | held[t];
    free_d = (free_q & ~alloc_m) | ret_m | fl_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q  <= '1;
      ilast_q <= ~THR_FIRST;
      clast_q <= ~THR_FIRST;
    end else begin
      free_q <= free_d;
      if (|ihas) ilast_q <= isel;
      if (|chas) clast_q <= csel;
    end
  end
endmodule

// File: rtl/inflight_tag_alloc_chk.sv
module inflight_tag_alloc_chk
  import inflight_tag_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 64,
  parameter int unsigned GRP      = 4,
  localparam int unsigned TW      = $clog2(NUM_TAGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NTHR-1:0]     thr_act_i,
  input logic [NTHR-1:0]     flush_i,
  input logic [NTHR*GRP-1:0] iss_vld_i,
  input logic [NTHR*GRP-1:0] iss_res_i,
  input logic [NTHR*GRP-1:0] cmt_rdy_i,
  input logic [GRP-1:0]      iss_gnt_o,
  input logic                iss_thr_o,
  input logic [GRP*TW-1:0]   iss_tag_o,
  input logic [GRP-1:0]      cmt_vld_o,
  input logic                cmt_thr_o,
  input logic [GRP*TW-1:0]   cmt_tag_o
);
  logic [NUM_TAGS-1:0] own_q [NTHR];
  logic                ipfx, cpfx, clash, stray;
  int unsigned         own_n, gnt_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NTHR; t++) own_q[t] <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        logic [NUM_TAGS-1:0] m;
        m = own_q[t];
        for (int k = 0; k < GRP; k++) begin
          if (cmt_vld_o[k] && cmt_thr_o == 1'(t)) m[cmt_tag_o[k*TW+:TW]] = 1'b0;
          if (iss_gnt_o[k] && iss_thr_o == 1'(t)) m[iss_tag_o[k*TW+:TW]] = 1'b1;
        end
        own_q[t] <= flush_i[t] ? '0 : m;
      end
    end
  end

  always_comb begin
    ipfx  = 1'b1;
    cpfx  = 1'b1;
    clash = 1'b0;
    stray = 1'b0;
    for (int k = 1; k < GRP; k++) begin
      if (iss_gnt_o[k] && !iss_gnt_o[k-1]) ipfx = 1'b0;
      if (cmt_vld_o[k] && !cmt_vld_o[k-1]) cpfx = 1'b0;
    end
    for (int k = 0; k < GRP; k++) begin
      if (iss_gnt_o[k] && (own_q[0][iss_tag_o[k*TW+:TW]] || own_q[1][iss_tag_o[k*TW+:TW]]))
        clash = 1'b1;
      if (cmt_vld_o[k] && !own_q[cmt_thr_o][cmt_tag_o[k*TW+:TW]]) stray = 1'b1;
    end
    own_n = $countones(own_q[iss_thr_o]);
    gnt_n = $countones(iss_gnt_o);
  end

  a_r2_issue_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni) ipfx);
  a_r5_commit_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni) cpfx);
  a_r1_fresh_tag: assert property (@(posedge clk_i) disable iff (!rst_ni) !clash);
  a_r5_owned_tag: assert property (@(posedge clk_i) disable iff (!rst_ni) !stray);
  a_r3_thread_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&thr_act_i) && (iss_gnt_o != '0)) |-> (own_n + gnt_n <= NUM_TAGS / NTHR));
  a_r7_flush_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[iss_thr_o] |-> (iss_gnt_o == '0));
  a_r7_flush_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[cmt_thr_o] |-> (cmt_vld_o == '0));
  a_r10_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_act_i[iss_thr_o] |-> (iss_gnt_o == '0));
endmodule

bind inflight_tag_alloc inflight_tag_alloc_chk #(.NUM_TAGS(NUM_TAGS), .GRP(GRP)) i_chk (.*);

// File: tb/test_inflight_tag_alloc.sv
module test_inflight_tag_alloc;
  localparam int unsigned TW = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  thr_act_i = '0, flush_i = '0;
  logic [7:0]  iss_vld_i = '0, iss_res_i = '0, cmt_rdy_i = '0;
  logic [3:0]  iss_gnt_o, cmt_vld_o;
  logic        iss_thr_o, cmt_thr_o;
  logic [23:0] iss_tag_o, cmt_tag_o;

  int errors = 0;
  int checks = 0;

  inflight_tag_alloc i_inflight_tag_alloc (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  act;
    logic [1:0]  fl;
    logic [7:0]  vld;
    logic [7:0]  res;
    logic [7:0]  rdy;
    logic [3:0]  gnt;
    logic        ithr;
    logic [23:0] itag;
    logic [3:0]  cvld;
    logic        cthr;
    logic [23:0] ctag;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    // full group to thread 0
    '{2'b11, 2'b00, 8'h0F, 8'h0F, 8'h00, 4'hF, 1'b0, {6'd3, 6'd2, 6'd1, 6'd0}, 4'h0, 1'b0, 24'd0},
    // thread 1 slot 2 blocked: only slots 0,1; commit t0 oldest two
    '{2'b11, 2'b00, 8'hFF, 8'hBF, 8'h03, 4'h3, 1'b1, {6'd0, 6'd0, 6'd5, 6'd4}, 4'h3, 1'b0, {6'd0, 6'd0, 6'd1, 6'd0}},
    // freed tags 0,1 reused; commit alternates to t1
    '{2'b11, 2'b00, 8'hFF, 8'hFF, 8'h1F, 4'hF, 1'b0, {6'd7, 6'd6, 6'd1, 6'd0}, 4'h1, 1'b1, {6'd0, 6'd0, 6'd0, 6'd4}},
    // t1 idle: issue falls back to t0; ready run 1011 retires two
    '{2'b11, 2'b00, 8'h0F, 8'h0D, 8'h1B, 4'h1, 1'b0, {6'd0, 6'd0, 6'd0, 6'd4}, 4'h3, 1'b0, {6'd0, 6'd0, 6'd3, 6'd2}},
    // flush t0 while t1 issues and commits
    '{2'b11, 2'b01, 8'h1F, 8'h1F, 8'h3F, 4'h1, 1'b1, {6'd0, 6'd0, 6'd0, 6'd2}, 4'h1, 1'b1, {6'd0, 6'd0, 6'd0, 6'd5}},
    // nothing to do; t0 empty despite ready bits
    '{2'b11, 2'b00, 8'h00, 8'hFF, 8'h0F, 4'h0, 1'b0, 24'd0, 4'h0, 1'b0, 24'd0},
    // flushed tags granted again; commit falls back to t1
    '{2'b11, 2'b00, 8'h0F, 8'h0F, 8'h10, 4'hF, 1'b0, {6'd4, 6'd3, 6'd1, 6'd0}, 4'h1, 1'b1, {6'd0, 6'd0, 6'd0, 6'd2}},
    // inactive thread 1 requests are ignored
    '{2'b01, 2'b00, 8'hF0, 8'hFF, 8'h00, 4'h0, 1'b1, 24'd0, 4'h0, 1'b0, 24'd0},
    // four commits in one cycle, oldest first
    '{2'b11, 2'b00, 8'h00, 8'h00, 8'h0F, 4'h0, 1'b1, 24'd0, 4'hF, 1'b0, {6'd4, 6'd3, 6'd1, 6'd0}}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] act, input logic [1:0] fl, input logic [7:0] vld,
                       input logic [7:0] res, input logic [7:0] rdy);
    @(posedge clk_i);
    #2;
    thr_act_i = act; flush_i = fl; iss_vld_i = vld; iss_res_i = res; cmt_rdy_i = rdy;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(posedge clk_i);
    #2;
    rst_ni = 1'b0;
    thr_act_i = '0; flush_i = '0; iss_vld_i = '0; iss_res_i = '0; cmt_rdy_i = '0;
    repeat (2) @(posedge clk_i);
    #2;
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] seen;
    int total, dup;

    do_reset();
    @(negedge clk_i);
    chk("R8 reset idle issue", {iss_gnt_o, iss_thr_o}, {4'h0, 1'b0});
    chk("R8 reset idle commit", {cmt_vld_o, cmt_thr_o}, {4'h0, 1'b0});

    for (int v = 0; v < NV; v++) begin
      apply(TBL[v].act, TBL[v].fl, TBL[v].vld, TBL[v].res, TBL[v].rdy);
      chk($sformatf("R1 R2 R4 R7 R10 issue vec %0d", v), {iss_gnt_o, iss_thr_o, iss_tag_o},
          {TBL[v].gnt, TBL[v].ithr, TBL[v].itag});
      chk($sformatf("R5 R6 R7 commit vec %0d", v), {cmt_vld_o, cmt_thr_o, cmt_tag_o},
          {TBL[v].cvld, TBL[v].cthr, TBL[v].ctag});
    end

    // R3: cap of 32 with both active, then 64 with one
    do_reset();
    seen = '0; total = 0; dup = 0;
    for (int c = 0; c < 9; c++) begin
      apply(2'b11, 2'b00, 8'h0F, 8'h0F, 8'h00);
      for (int k = 0; k < 4; k++) if (iss_gnt_o[k]) begin
        total++;
        if (seen[iss_tag_o[k*TW+:TW]]) dup++;
        seen[iss_tag_o[k*TW+:TW]] = 1'b1;
      end
    end
    chk("R3 both-active cap", 64'(total), 64'd32);
    for (int c = 0; c < 9; c++) begin
      apply(2'b01, 2'b00, 8'h0F, 8'h0F, 8'h00);
      for (int k = 0; k < 4; k++) if (iss_gnt_o[k]) begin
        total++;
        if (seen[iss_tag_o[k*TW+:TW]]) dup++;
        seen[iss_tag_o[k*TW+:TW]] = 1'b1;
      end
    end
    chk("R3 single-thread fill", 64'(total), 64'd64);
    chk("R1 no duplicate tag", 64'(dup), 64'd0);
    chk("R1 all tags used", seen, {64{1'b1}});

    // R9: pool empty, commit frees 0..3, t1 cannot take them this cycle
    apply(2'b11, 2'b00, 8'hF0, 8'hF0, 8'h0F);
    chk("R9 no same-cycle reuse", {iss_gnt_o}, 64'h0);
    chk("R5 oldest retired", {cmt_vld_o, cmt_thr_o, cmt_tag_o},
        {4'hF, 1'b0, 6'd3, 6'd2, 6'd1, 6'd0});
    apply(2'b11, 2'b00, 8'hF0, 8'hF0, 8'h00);
    chk("R9 reuse next cycle", {iss_gnt_o, iss_thr_o, iss_tag_o},
        {4'hF, 1'b1, 6'd3, 6'd2, 6'd1, 6'd0});
    // t0 holds 60 > 32: granted nothing
    apply(2'b11, 2'b00, 8'h0F, 8'h0F, 8'h00);
    chk("R3 over-cap thread blocked", {iss_gnt_o}, 64'h0);

    // R7: flush t0 frees its tags at once
    apply(2'b11, 2'b01, 8'h0F, 8'h0F, 8'h0F);
    chk("R7 flush suppresses", {iss_gnt_o, cmt_vld_o}, 64'h0);
    apply(2'b11, 2'b00, 8'h0F, 8'h0F, 8'h00);
    chk("R7 flushed tags reusable", {iss_gnt_o, iss_thr_o, iss_tag_o},
        {4'hF, 1'b0, 6'd7, 6'd6, 6'd5, 6'd4});

    // R8: reset in the middle of a run
    do_reset();
    @(negedge clk_i);
    chk("R8 nothing in flight", {cmt_vld_o}, 64'h0);
    apply(2'b11, 2'b00, 8'hFF, 8'hFF, 8'hFF);
    chk("R8 fresh pool thread 0 first", {iss_gnt_o, iss_thr_o, iss_tag_o, cmt_vld_o},
        {4'hF, 1'b0, 6'd3, 6'd2, 6'd1, 6'd0, 4'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule